// File: doc/BRIEF.md
# Fractional-N Divide and Residue-Weight Controller

This block sits between a fractional frequency word and the divider and split phase detector of a fractional-N synthesizer. It acts once per divider cycle, on a strobe. Each cycle it produces three things: the integer divide value for the divider, and a pair of complementary weights for the two weighted detector paths. One detector path sees the delayed divider edge and the other sees the undelayed edge. The fractional accumulator's leftover residue sets the weight of the delayed path, and the other path receives the complement. The two weights scale the detector currents so that the error pulse area stays constant from cycle to cycle, which removes fractional spurs.

A pseudo-random bit can exchange the two edges between the paths. The controller then exchanges the weights as well, so each weight stays attached to its edge. This turns any timing mismatch between the paths into broadband noise. Two further modes are available. Integer mode holds the residue at zero. Second-order noise-shaping mode dithers the divide value and sends a zero residue to the weights. Configuration is written at any time and is applied at the next strobe. All outputs are registered and change together on the strobe.

Top module: `frac_residue_ctrl`

## Requirements
- R1: After reset the outputs are: divide value 73, `wt_a` = 0, `wt_b` = 128, `path_swap` = 0. The configuration resets to integer mode with divide 73, fractional word 0 and swapping off.
- R2: A configuration write is used from the next `cyc_stb` edge onward. No output changes on a cycle without `cyc_stb`.
- R3: When `cfg_mode` is 0 or 3 (integer), the divide value equals the configured integer. The residue is 0, whatever the fractional word. Each integer-mode strobe clears all modulator state.
- R4: When `cfg_mode` is 1 (fractional), each strobe adds the 7-bit word to a 7-bit accumulator. A carry out gives divide N+1, otherwise N. The residue ε is the new accumulator value. Starting from a cleared accumulator, exactly `frac` of any 128 consecutive strobes give N+1.
- R5: In fractional mode with a zero word and a cleared accumulator, the residue stays 0 and the divide value stays N.
- R6: `wt_a` + `wt_b` equals 128 at all times. Both are 8-bit unsigned.
- R7: With swapping disabled, `path_swap` is 0, `wt_a` = ε (delayed-edge path) and `wt_b` = 128 − ε.
- R8: A 15-bit LFSR seeded to 1 advances on every strobe, with feedback bit s[14] XOR s[13] shifted in at bit 0. With swapping enabled, `path_swap` takes s[14] of the state before the step. When `path_swap` is 1, `wt_a` = 128 − ε and `wt_b` = ε.
- R9: When `cfg_mode` is 2 (noise-shaped), two cascaded 7-bit accumulators are used. The second adds the first's new value. The divide value is N + c1 + c2 − c2 of the previous strobe, which lies in N−1..N+2. ε is forced to 0, so the delayed-edge weight is 0.
- R10: After an integer-mode strobe, accumulation in fractional mode restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_int | input | INT_W (8) | Integer divide value N (2 or more) |
| cfg_frac | input | FRAC_W (7) | Fractional word |
| cfg_mode | input | 2 | 0/3 integer, 1 fractional, 2 noise-shaped |
| cfg_swap_en | input | 1 | Enables pseudo-random path swapping |
| cyc_stb | input | 1 | One-cycle pulse per divider cycle |
| div_val | output | INT_W+1 (9) | Divide value for this cycle |
| wt_a | output | FRAC_W+1 (8) | Weight of detector path A |
| wt_b | output | FRAC_W+1 (8) | Weight of detector path B |
| path_swap | output | 1 | 1 when the edges are exchanged between paths |

## Verification
The bench aims at the carry boundary: a word of 64 must alternate N and N+1, and a design that drops the carry or keeps one bit too many would never reach N+1 or would wrap at the wrong point. It tests that the weights follow the edge on a swap. A design that exchanges the edges but not the weights would put 1−ε on the delayed edge, and the bench would see the residue on the wrong output. It checks that noise-shaped mode forces ε to zero and keeps the divide value within N−1..N+2. It also checks that returning from integer mode restarts the accumulator. A design that keeps stale state would show a first residue different from the word.

// File: rtl/fnr_pkg.sv
// Shared definitions for the fractional-N residue controller.
// Assumes: mode codes are fixed by the configuration port encoding.
package fnr_pkg;
    typedef enum logic [1:0] {
        FNR_INT     = 2'd0,
        FNR_FRAC    = 2'd1,
        FNR_SD2     = 2'd2,
        FNR_INT_ALT = 2'd3
    } fnr_mode_e;
endpackage

// File: rtl/fnr_prbs.sv
// Maximal-length Fibonacci LFSR that advances one step per request.
// Outputs the top state bit before the step.
// Assumes: SEED is non-zero and the two taps give a maximal sequence.
module fnr_prbs #(
    parameter int             W    = 15,
    parameter int             TAP  = 13,
    parameter logic [W-1:0]   SEED = {{(W-1){1'b0}}, 1'b1}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic msb_o
);
    logic [W-1:0] state_q;

    // Shift in the XOR of the top bit and the tap bit on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (step)
            state_q <= {state_q[W-2:0], state_q[W-1] ^ state_q[TAP]};
    end

    assign msb_o = state_q[W-1];
endmodule

// File: rtl/fnr_modulator.sv
// Divide-offset and residue generator.
// Fractional mode runs a first-order accumulator, noise-shaped mode a
// cascade of two, and integer mode clears the state.
// Offset and residue are combinational from the present state and inputs.
// Assumes: the state advances only when step is high.
module fnr_modulator
    import fnr_pkg::*;
#(
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  fnr_mode_e     mode,
    input  logic [FW-1:0] frac,
    output logic [2:0]    offset_o,
    output logic [FW-1:0] resid_o
);
    logic [FW-1:0] a1_q, a2_q;
    logic          c2p_q;
    logic [FW:0]   s1, s2;
    logic [FW-1:0] a1_d, a2_d;
    logic          c2p_d;

    // First and second stage sums with their carries.
    always_comb begin
        s1 = {1'b0, a1_q} + {1'b0, frac};
        s2 = {1'b0, a2_q} + {1'b0, s1[FW-1:0]};
    end

    // Select offset, residue and next state for the active mode.
    always_comb begin
        case (mode)
            FNR_FRAC: begin
                offset_o = {2'b00, s1[FW]};
                resid_o  = s1[FW-1:0];
                a1_d     = s1[FW-1:0];
                a2_d     = '0;
                c2p_d    = 1'b0;
            end
            FNR_SD2: begin
                offset_o = {2'b00, s1[FW]} + {2'b00, s2[FW]} - {2'b00, c2p_q};
                resid_o  = '0;
                a1_d     = s1[FW-1:0];
                a2_d     = s2[FW-1:0];
                c2p_d    = s2[FW];
            end
            default: begin
                offset_o = 3'd0;
                resid_o  = '0;
                a1_d     = '0;
                a2_d     = '0;
                c2p_d    = 1'b0;
            end
        endcase
    end

    // Advance the accumulator state once per divider cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1_q  <= '0;
            a2_q  <= '0;
            c2p_q <= 1'b0;
        end else if (step) begin
            a1_q  <= a1_d;
            a2_q  <= a2_d;
            c2p_q <= c2p_d;
        end
    end
endmodule

// File: rtl/fnr_weight_split.sv
// Splits a residue into complementary path weights that sum to 2^FW.
// When the edges are swapped, the weights are exchanged with them.
// Assumes: path A carries the delayed edge when swap is low.
module fnr_weight_split #(
    parameter int FW = 7
) (
    input  logic [FW-1:0] resid,
    input  logic          swap,
    output logic [FW:0]   wt_a,
    output logic [FW:0]   wt_b
);
    localparam logic [FW:0] FULL = (FW+1)'(1) << FW;

    logic [FW:0] eps, comp;

    // Route the residue to the delayed edge and its complement to the other path.
    always_comb begin
        eps  = {1'b0, resid};
        comp = FULL - eps;
        wt_a = swap ? comp : eps;
        wt_b = swap ? eps  : comp;
    end
endmodule

// File: rtl/frac_residue_ctrl.sv
// Top of the fractional-N residue controller.
// Holds the configuration written through the config port.
// On each divider strobe it registers the divide value, the two path
// weights and the swap bit, so all four belong to the same cycle.
// Assumes: cfg_int >= 2; cyc_stb is a single-cycle pulse.
module frac_residue_ctrl
    import fnr_pkg::*;
#(
    parameter int INT_W     = 8,
    parameter int FRAC_W    = 7,
    parameter int LFSR_W    = 15,
    parameter int LFSR_TAP  = 13,
    parameter int LFSR_SEED = 1,
    parameter int DEF_INT   = 73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [INT_W-1:0]  cfg_int,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_swap_en,
    input  logic              cyc_stb,
    output logic [INT_W:0]    div_val,
    output logic [FRAC_W:0]   wt_a,
    output logic [FRAC_W:0]   wt_b,
    output logic              path_swap
);
    localparam logic [FRAC_W:0] FULL = (FRAC_W+1)'(1) << FRAC_W;

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    fnr_mode_e         mode_q;
    logic              swap_en_q;

    logic              prbs_bit, swap_now;
    logic [2:0]        offset;
    logic [FRAC_W-1:0] resid;
    logic [FRAC_W:0]   wa_d, wb_d;
    logic [INT_W:0]    div_d;

    // Capture configuration writes; they are applied at the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q     <= INT_W'(DEF_INT);
            frac_q    <= '0;
            mode_q    <= FNR_INT;
            swap_en_q <= 1'b0;
        end else if (cfg_we) begin
            int_q     <= cfg_int;
            frac_q    <= cfg_frac;
            mode_q    <= fnr_mode_e'(cfg_mode);
            swap_en_q <= cfg_swap_en;
        end
    end

    fnr_prbs #(
        .W    (LFSR_W),
        .TAP  (LFSR_TAP),
        .SEED (LFSR_W'(LFSR_SEED))
    ) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cyc_stb),
        .msb_o (prbs_bit)
    );

    fnr_modulator #(.FW(FRAC_W)) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (cyc_stb),
        .mode     (mode_q),
        .frac     (frac_q),
        .offset_o (offset),
        .resid_o  (resid)
    );

    assign swap_now = swap_en_q & prbs_bit;

    fnr_weight_split #(.FW(FRAC_W)) u_split (
        .resid (resid),
        .swap  (swap_now),
        .wt_a  (wa_d),
        .wt_b  (wb_d)
    );

    // Add the sign-extended offset (-1..+2) to the integer divide value.
    always_comb begin
        div_d = {1'b0, int_q} + {{(INT_W-2){offset[2]}}, offset};
    end

    // Register all outputs together on the divider-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val   <= (INT_W+1)'(DEF_INT);
            wt_a      <= '0;
            wt_b      <= FULL;
            path_swap <= 1'b0;
        end else if (cyc_stb) begin
            div_val   <= div_d;
            wt_a      <= wa_d;
            wt_b      <= wb_d;
            path_swap <= swap_now;
        end
    end
endmodule

// File: rtl/fnr_ctrl_chk.sv
// Property checker for frac_residue_ctrl; attached by bind below.
// Assumes: internal configuration registers are visible through the bind.
module fnr_ctrl_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_stb,
    input logic [INT_W-1:0]  int_q,
    input logic [1:0]        mode_q,
    input logic              swap_en_q,
    input logic [INT_W:0]    div_val,
    input logic [FRAC_W:0]   wt_a,
    input logic [FRAC_W:0]   wt_b,
    input logic              path_swap
);
    localparam logic [FRAC_W+1:0] FULL = (FRAC_W+2)'(1) << FRAC_W;

    p_weight_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, wt_a} + {1'b0, wt_b}) == FULL);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> ($stable(div_val) && $stable(wt_a) && $stable(wt_b) && $stable(path_swap)));

    p_int_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && (mode_q == 2'd0 || mode_q == 2'd3)) |=>
        (div_val == {1'b0, $past(int_q)}) && (path_swap ? (wt_b == '0) : (wt_a == '0)));

    p_frac_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && mode_q == 2'd1) |=>
        (div_val == {1'b0, $past(int_q)}) || (div_val == {1'b0, $past(int_q)} + 1'b1));

    p_no_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !swap_en_q) |=> !path_swap);

    p_sd_zero_resid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && mode_q == 2'd2) |=>
        (path_swap ? (wt_b == '0) : (wt_a == '0)) &&
        ({1'b0, div_val} + 1'b1 >= {2'b00, $past(int_q)}) &&
        ({1'b0, div_val} <= {2'b00, $past(int_q)} + 2'd2));
endmodule

bind frac_residue_ctrl fnr_ctrl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_stb   (cyc_stb),
    .int_q     (int_q),
    .mode_q    (mode_q),
    .swap_en_q (swap_en_q),
    .div_val   (div_val),
    .wt_a      (wt_a),
    .wt_b      (wt_b),
    .path_swap (path_swap)
);

// File: tb/sim_frac_residue_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random configurations,
// compared against a behavioural model written from the requirements.
module sim_frac_residue_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_int = 8'd73;
    logic [6:0] cfg_frac = 7'd0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_swap_en = 1'b0;
    logic       cyc_stb = 1'b0;
    logic [8:0] div_val;
    logic [7:0] wt_a, wt_b;
    logic       path_swap;

    int n_chk = 0;
    int n_err = 0;

    // expected configuration and model state
    int e_int = 73, e_frac = 0, e_mode = 0, e_swen = 0;
    int m_a1 = 0, m_a2 = 0, m_c2p = 0, m_lfsr = 1;
    int e_div = 73, e_wa = 0, e_wb = 128, e_sw = 0;

    always #2 clk = ~clk;

    frac_residue_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_int(cfg_int),
        .cfg_frac(cfg_frac), .cfg_mode(cfg_mode), .cfg_swap_en(cfg_swap_en),
        .cyc_stb(cyc_stb), .div_val(div_val), .wt_a(wt_a), .wt_b(wt_b),
        .path_swap(path_swap)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input int ni, input int nf, input int nm, input int ns);
        @(negedge clk);
        cfg_we = 1'b1; cfg_int = 8'(ni); cfg_frac = 7'(nf);
        cfg_mode = 2'(nm); cfg_swap_en = 1'(ns);
        @(negedge clk);
        cfg_we = 1'b0;
        e_int = ni; e_frac = nf; e_mode = nm; e_swen = ns;
    endtask

    // Advance the reference model by one divider cycle.
    task automatic model_step();
        int s1, c1, n1, s2, c2, n2, off, eps, top;
        top = (m_lfsr >> 14) & 1;
        e_sw = e_swen & top;
        m_lfsr = ((m_lfsr << 1) & 32'h7fff) | (top ^ ((m_lfsr >> 13) & 1));
        s1 = m_a1 + e_frac; c1 = (s1 >= 128) ? 1 : 0; n1 = s1 % 128;
        if (e_mode == 1) begin
            off = c1; eps = n1; m_a1 = n1; m_a2 = 0; m_c2p = 0;
        end else if (e_mode == 2) begin
            s2 = m_a2 + n1; c2 = (s2 >= 128) ? 1 : 0; n2 = s2 % 128;
            off = c1 + c2 - m_c2p; eps = 0;
            m_a1 = n1; m_a2 = n2; m_c2p = c2;
        end else begin
            off = 0; eps = 0; m_a1 = 0; m_a2 = 0; m_c2p = 0;
        end
        e_div = e_int + off;
        e_wa = e_sw ? 128 - eps : eps;
        e_wb = 128 - e_wa;
    endtask

    // Pulse the strobe, then compare all outputs away from the clock edge.
    task automatic strobe();
        string dt;
        @(negedge clk);
        cyc_stb = 1'b1;
        model_step();
        @(negedge clk);
        cyc_stb = 1'b0;
        dt = (e_mode == 1) ? "R4" : (e_mode == 2) ? "R9" : "R3";
        check(dt, int'(div_val), e_div);
        check(e_sw ? "R8" : dt, int'(wt_a), e_wa);
        check("R6", int'(wt_a) + int'(wt_b), 128);
        check(e_swen ? "R8" : "R7", int'(path_swap), e_sw);
    endtask

    initial begin
        int cnt;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(div_val), 73);
        check("R1", int'(wt_a), 0);
        check("R1", int'(wt_b), 128);
        check("R1", int'(path_swap), 0);

        // R2: a write alone changes no output
        cfg_write(73, 64, 1, 0);
        repeat (4) @(negedge clk);
        check("R2", int'(div_val), 73);
        check("R2", int'(wt_a), 0);
        // R4 carry boundary with word 64: alternates N, N+1
        strobe(); check("R4", int'(wt_a), 64);
        strobe(); check("R4", int'(div_val), 74);
        repeat (4) strobe();

        // R3: integer mode ignores the fractional word
        cfg_write(90, 99, 0, 0);
        repeat (3) strobe();
        cfg_write(90, 99, 3, 0);
        strobe(); check("R3", int'(div_val), 90);

        // R5: zero word from a cleared accumulator
        cfg_write(73, 0, 1, 0);
        repeat (5) strobe();
        check("R5", int'(wt_a), 0);
        check("R5", int'(div_val), 73);

        // R4 long-run: exactly frac carries in 128 strobes from zero
        cfg_write(73, 0, 0, 0); strobe();
        cfg_write(73, 37, 1, 0);
        cnt = 0;
        for (int i = 0; i < 128; i++) begin
            strobe();
            if (div_val == 9'd74) cnt++;
        end
        check("R4", cnt, 37);

        // R10: integer strobe restarts accumulation
        cfg_write(73, 100, 1, 0); repeat (3) strobe();
        cfg_write(73, 100, 0, 0); strobe();
        cfg_write(73, 100, 1, 0); strobe();
        check("R10", int'(wt_a), 100);

        // R9: noise-shaped mode, residue forced to zero
        cfg_write(73, 45, 2, 0);
        repeat (64) strobe();
        cfg_write(73, 127, 2, 1);
        repeat (32) strobe();

        // R8: swapping in fractional mode
        cfg_write(73, 23, 1, 1);
        cnt = 0;
        for (int i = 0; i < 64; i++) begin
            strobe();
            if (path_swap) cnt++;
        end
        check("R8", (cnt > 0) ? 1 : 0, 1);

        // Random mix of configurations
        for (int k = 0; k < 60; k++) begin
            cfg_write(2 + ($urandom % 253), $urandom % 128, $urandom % 4, $urandom % 2);
            repeat (1 + ($urandom % 8)) strobe();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule